// File: doc/BRIEF.md
# Vector Pattern Sequencer

The sequencer plays test vectors out of a small on-chip pattern store at one vector per clock. Every stored word carries a vector payload together with a sequencing instruction. The instruction decides which word runs next. The instruction set covers a plain step, a counted block loop, an uncounted block loop that runs until a match input fires, a conditional branch on a parallel or serial match, a wait for a software trigger, a change of the active timing set, and a halt. Downstream formatters receive the vector and the timing-set index that goes with it.

A host write port loads whole words, which is how instructions get into the store. It can also replace only the vector payload of a word and leave the instruction fields alone. This lets a pattern template be reused with new data without rebuilding the sequence. After `start` is pulsed while the block is idle, execution begins at address 0 and continues until a halt word runs.

Top module: `vec_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `vec_valid`=0, `active`=0, `vec_out`=0 and `tset_out`=0.
- R2: Each stored word has the layout: bits [7:0] vector, [15:8] operand, [17:16] timing set, [18] match select, [21:19] opcode. The opcodes are 0 step, 1 loop-begin, 2 loop-end, 3 until, 4 branch, 5 wait, 6 set-timing and 7 halt. A `start` sampled while idle begins execution at address 0, with the active timing set cleared to 0. The vector of word 0 appears with `vec_valid`=1 after the second rising edge from that sample. Each step word then emits its vector and advances one address per cycle.
- R3: A loop-begin word emits its vector and loads its operand as a pass count. A loop-end word emits its vector and then jumps to its operand address until the final pass is done, after which it falls through. A count of N runs the block N times, and counts of 1 and 0 both run it once.
- R4: An until word emits its vector and then jumps to its operand address, unless the selected match input is high in the cycle the word executes. In that case execution falls through to the next address.
- R5: A branch word emits its vector and then jumps to its operand address when the selected match input is high, and otherwise goes to the next address. Match select 0 picks `match_par` and 1 picks `match_ser`.
- R6: A wait word emits its vector and then holds `vec_out`, `tset_out` and `vec_valid`=1 with `active`=1. A `sw_trig` sampled high while waiting makes the next word's vector appear at that same edge.
- R7: A set-timing word makes its timing-set field the `tset_out` value for its own vector and for every later vector of the run.
- R8: A halt word emits no vector. At the edge where it executes, `vec_valid` and `active` fall, and `vec_out` keeps its last value while idle.
- R9: A host write with `host_full`=1 replaces the whole word. With `host_full`=0 it replaces only bits [7:0] and keeps the instruction fields.
- R10: When the host writes a word in the same cycle that the sequencer executes that word, the old content is used and the new content takes effect from the next execution.
- R11: A `start` sampled while `active` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run at address 0 (used only while idle) |
| sw_trig | input | 1 | Software trigger that releases a wait |
| match_par | input | 1 | Parallel pattern match flag |
| match_ser | input | 1 | Serial pattern match flag |
| host_we | input | 1 | Host write strobe |
| host_full | input | 1 | 1: write the whole word, 0: write the vector field only |
| host_addr | input | 5 | Host write address |
| host_wdata | input | 22 | Host write data in the stored-word layout |
| vec_out | output | 8 | Current vector to the formatters |
| tset_out | output | 2 | Timing set for the current vector |
| vec_valid | output | 1 | A vector is being presented |
| active | output | 1 | A run is in progress, including waits |

## Verification
The first vector of a run is due two rising edges after `start` is sampled. After that, each executed word's vector is due at the edge that executes it. When a trigger is sampled during a wait, the next vector is due at that same edge, and a halt drops `vec_valid` at its own execution edge. The bench drives every input just after a falling edge and samples at the following falling edge, so each check counts whole edges from the edge that sampled its stimulus. Match inputs, trigger pulses and host writes are timed to land at the exact edge where the intended word executes.

// File: rtl/vec_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared opcode and state encodings of the vector pattern sequencer.
// Assumes: the opcode field of a stored word is exactly OP_W bits wide.
package vec_seq_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_STEP   = 3'd0,
        OP_LBEG   = 3'd1,
        OP_LEND   = 3'd2,
        OP_UNTIL  = 3'd3,
        OP_BRANCH = 3'd4,
        OP_WAIT   = 3'd5,
        OP_SETTS  = 3'd6,
        OP_HALT   = 3'd7
    } vs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } vs_state_e;
endpackage

// File: rtl/vec_seq_mem.sv
`timescale 1ns/1ps
// Module: pattern store. Register array with a combinational read port for the
// sequencer and a host write port that writes either a whole word or only the
// low VEC_W vector bits.
// Assumes: contents are loaded by the host before a run; there is no reset, so
// the words hold undefined values until they are written.
module vec_seq_mem #(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 22,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              vec_only,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store_q [DEPTH];

    // Host write: full word, or vector field merged with the kept instruction bits.
    always_ff @(posedge clk) begin
        if (we) begin
            if (vec_only) begin
                store_q[waddr] <= {store_q[waddr][WORD_W-1:VEC_W], wdata[VEC_W-1:0]};
            end else begin
                store_q[waddr] <= wdata;
            end
        end
    end

    // Sequencer read: sees the pre-write content during a same-cycle write.
    assign rdata = store_q[raddr];
endmodule

// File: rtl/vec_seq_loop.sv
`timescale 1ns/1ps
// Module: pass counter for counted block loops. It loads when a loop-begin word
// executes and decrements when a loop-end word executes.
// Assumes: one counted loop is open at a time; a load value of 0 counts as 1.
module vec_seq_loop #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             pass_end,
    output logic             last_pass
);
    logic [CNT_W-1:0] cnt_q;

    // Pass count: load at block entry, step down at each block end, clear on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? CNT_W'(1) : load_val;
        end else if (pass_end) begin
            cnt_q <= last_pass ? '0 : cnt_q - CNT_W'(1);
        end
    end

    // The current pass is the final one when at most one pass remains.
    always_comb begin
        last_pass = (cnt_q <= CNT_W'(1));
    end
endmodule

// File: rtl/vec_seq_step.sv
`timescale 1ns/1ps
// Module: instruction decoder. From the executing word's opcode, the match flag
// and the loop state, it computes the next address and the side effects.
// Assumes: purely combinational; the caller gates the side effects with its
// execute strobe.
module vec_seq_step
    import vec_seq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  vs_op_e            op,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    input  logic              match_hit,
    input  logic              loop_last,
    output logic [ADDR_W-1:0] pc_next,
    output logic              go_wait,
    output logic              go_halt,
    output logic              ld_loop,
    output logic              end_pass,
    output logic              set_ts
);
    logic [ADDR_W-1:0] pc_inc;

    assign pc_inc = pc + ADDR_W'(1);

    // Opcode decode: next address and side effects of one executed word.
    always_comb begin
        pc_next  = pc_inc;
        go_wait  = 1'b0;
        go_halt  = 1'b0;
        ld_loop  = 1'b0;
        end_pass = 1'b0;
        set_ts   = 1'b0;
        unique case (op)
            OP_STEP:   pc_next = pc_inc;
            OP_LBEG:   ld_loop = 1'b1;
            OP_LEND: begin
                end_pass = 1'b1;
                pc_next  = loop_last ? pc_inc : target;
            end
            OP_UNTIL:  pc_next = match_hit ? pc_inc : target;
            OP_BRANCH: pc_next = match_hit ? target : pc_inc;
            OP_WAIT:   go_wait = 1'b1;
            OP_SETTS:  set_ts  = 1'b1;
            OP_HALT: begin
                go_halt = 1'b1;
                pc_next = pc;
            end
            default:   pc_next = pc_inc;
        endcase
    end
endmodule

// File: rtl/vec_seq.sv
`timescale 1ns/1ps
// Module: vector pattern sequencer top. It fetches one stored word per cycle,
// executes its instruction, and registers the word's vector and timing set
// toward the formatters.
// Assumes: ADDR_W <= OPND_W (branch targets sit in the low operand bits); the
// host loads the program before pulsing start.
module vec_seq
    import vec_seq_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 5,
    parameter int TS_W   = 2,
    parameter int OPND_W = 8,
    localparam int WORD_W = OP_W + 1 + TS_W + OPND_W + VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sw_trig,
    input  logic              match_par,
    input  logic              match_ser,
    input  logic              host_we,
    input  logic              host_full,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [VEC_W-1:0]  vec_out,
    output logic [TS_W-1:0]   tset_out,
    output logic              vec_valid,
    output logic              active
);
    localparam int OPND_LO  = VEC_W;
    localparam int TS_LO    = OPND_LO + OPND_W;
    localparam int MSEL_BIT = TS_LO + TS_W;
    localparam int OP_LO    = MSEL_BIT + 1;

    vs_state_e         state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [TS_W-1:0]   tset_q;
    logic [WORD_W-1:0] word;
    vs_op_e            w_op;
    logic              w_msel;
    logic [TS_W-1:0]   w_ts;
    logic [OPND_W-1:0] w_opnd;
    logic [VEC_W-1:0]  w_vec;
    logic              exec;
    logic              match_hit;
    logic              loop_last;
    logic [ADDR_W-1:0] pc_next;
    logic              go_wait;
    logic              go_halt;
    logic              ld_loop;
    logic              end_pass;
    logic              set_ts;

    vec_seq_mem #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .VEC_W (VEC_W)
    ) u_mem (
        .clk     (clk),
        .we      (host_we),
        .vec_only(!host_full),
        .waddr   (host_addr),
        .wdata   (host_wdata),
        .raddr   (pc_q),
        .rdata   (word)
    );

    // Field split of the word being executed.
    always_comb begin
        w_op   = vs_op_e'(word[OP_LO +: OP_W]);
        w_msel = word[MSEL_BIT];
        w_ts   = word[TS_LO +: TS_W];
        w_opnd = word[OPND_LO +: OPND_W];
        w_vec  = word[VEC_W-1:0];
    end

    // Execute strobe and match source selection.
    always_comb begin
        exec      = (state_q == ST_RUN) || ((state_q == ST_WAIT) && sw_trig);
        match_hit = w_msel ? match_ser : match_par;
    end

    vec_seq_step #(
        .ADDR_W(ADDR_W)
    ) u_step (
        .op       (w_op),
        .pc       (pc_q),
        .target   (w_opnd[ADDR_W-1:0]),
        .match_hit(match_hit),
        .loop_last(loop_last),
        .pc_next  (pc_next),
        .go_wait  (go_wait),
        .go_halt  (go_halt),
        .ld_loop  (ld_loop),
        .end_pass (end_pass),
        .set_ts   (set_ts)
    );

    vec_seq_loop #(
        .CNT_W(OPND_W)
    ) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (exec && ld_loop),
        .load_val (w_opnd),
        .pass_end (exec && end_pass),
        .last_pass(loop_last)
    );

    // Sequencer state, program counter and registered vector output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pc_q      <= '0;
            tset_q    <= '0;
            vec_out   <= '0;
            tset_out  <= '0;
            vec_valid <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                state_q <= ST_RUN;
                pc_q    <= '0;
                tset_q  <= '0;
            end
        end else if (exec) begin
            pc_q <= pc_next;
            if (go_halt) begin
                state_q   <= ST_IDLE;
                vec_valid <= 1'b0;
            end else begin
                state_q   <= go_wait ? ST_WAIT : ST_RUN;
                vec_out   <= w_vec;
                vec_valid <= 1'b1;
                tset_out  <= set_ts ? w_ts : tset_q;
                if (set_ts) begin
                    tset_q <= w_ts;
                end
            end
        end
    end

    // Run flag seen by the system: high from start until a halt executes.
    assign active = (state_q != ST_IDLE);
endmodule

// File: rtl/vec_seq_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for vec_seq, attached with bind below.
// Assumes: state is the sequencer's internal state register.
module vec_seq_chk
    import vec_seq_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int TS_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sw_trig,
    input logic [VEC_W-1:0] vec_out,
    input logic [TS_W-1:0]  tset_out,
    input logic             vec_valid,
    input logic             active,
    input logic [1:0]       state
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!vec_valid && !active && vec_out == '0 && tset_out == '0));

    p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (active && !vec_valid));

    p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !sw_trig) |=> ($stable(vec_out) && $stable(tset_out) && vec_valid));

    p_valid_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> active);

    p_idle_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(vec_out) && !vec_valid));

    p_wait_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !sw_trig) |=> (state == ST_WAIT));
endmodule

bind vec_seq vec_seq_chk #(
    .VEC_W(VEC_W),
    .TS_W (TS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sw_trig  (sw_trig),
    .vec_out  (vec_out),
    .tset_out (tset_out),
    .vec_valid(vec_valid),
    .active   (active),
    .state    (state_q)
);

// File: tb/vec_seq_bench.sv
`timescale 1ns/1ps
// Bench: loads a program from a table, walks the expected vector stream with
// one loop, then runs directed tests for wait, until, host writes and reset.
module vec_seq_bench;
    localparam int VEC_W  = 8;
    localparam int ADDR_W = 5;
    localparam int TS_W   = 2;
    localparam int WORD_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              sw_trig = 1'b0;
    logic              match_par = 1'b0;
    logic              match_ser = 1'b0;
    logic              host_we = 1'b0;
    logic              host_full = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [WORD_W-1:0] host_wdata = '0;
    logic [VEC_W-1:0]  vec_out;
    logic [TS_W-1:0]   tset_out;
    logic              vec_valid;
    logic              active;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    vec_seq u_vec_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sw_trig   (sw_trig),
        .match_par (match_par),
        .match_ser (match_ser),
        .host_we   (host_we),
        .host_full (host_full),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .vec_out   (vec_out),
        .tset_out  (tset_out),
        .vec_valid (vec_valid),
        .active    (active)
    );

    // Program A: {opcode, msel, tset, operand, vector}
    localparam logic [WORD_W-1:0] PROG_A [15] = '{
        {3'd0, 1'b0, 2'd0, 8'd0,  8'h10},
        {3'd6, 1'b0, 2'd2, 8'd0,  8'h11},
        {3'd1, 1'b0, 2'd0, 8'd3,  8'h12},
        {3'd0, 1'b0, 2'd0, 8'd0,  8'h13},
        {3'd2, 1'b0, 2'd0, 8'd3,  8'h14},
        {3'd1, 1'b0, 2'd0, 8'd1,  8'h15},
        {3'd2, 1'b0, 2'd0, 8'd6,  8'h16},
        {3'd1, 1'b0, 2'd0, 8'd0,  8'h17},
        {3'd2, 1'b0, 2'd0, 8'd8,  8'h18},
        {3'd4, 1'b0, 2'd0, 8'd12, 8'h19},
        {3'd4, 1'b1, 2'd0, 8'd13, 8'h1A},
        {3'd0, 1'b0, 2'd0, 8'd0,  8'h1B},
        {3'd0, 1'b0, 2'd0, 8'd0,  8'h1C},
        {3'd6, 1'b0, 2'd1, 8'd0,  8'h1D},
        {3'd7, 1'b0, 2'd0, 8'd0,  8'h1E}
    };

    // Expected stream of program A with match_par=0, match_ser=1: {valid, tset, vector}
    localparam logic [10:0] EXP_A [16] = '{
        {1'b1, 2'd0, 8'h10}, {1'b1, 2'd2, 8'h11}, {1'b1, 2'd2, 8'h12},
        {1'b1, 2'd2, 8'h13}, {1'b1, 2'd2, 8'h14}, {1'b1, 2'd2, 8'h13},
        {1'b1, 2'd2, 8'h14}, {1'b1, 2'd2, 8'h13}, {1'b1, 2'd2, 8'h14},
        {1'b1, 2'd2, 8'h15}, {1'b1, 2'd2, 8'h16}, {1'b1, 2'd2, 8'h17},
        {1'b1, 2'd2, 8'h18}, {1'b1, 2'd2, 8'h19}, {1'b1, 2'd2, 8'h1A},
        {1'b1, 2'd1, 8'h1D}
    };

    // Program B: step, until-par on itself, wait, step, halt.
    localparam logic [WORD_W-1:0] PROG_B [5] = '{
        {3'd0, 1'b0, 2'd0, 8'd0, 8'h20},
        {3'd3, 1'b0, 2'd0, 8'd1, 8'h21},
        {3'd5, 1'b0, 2'd0, 8'd0, 8'h22},
        {3'd0, 1'b0, 2'd0, 8'd0, 8'h23},
        {3'd7, 1'b0, 2'd0, 8'd0, 8'h24}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d, input logic full);
        @(negedge clk);
        host_we = 1'b1;
        host_full = full;
        host_addr = a;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(vec_valid), 32'd0);
        check("R1 active", 32'(active), 32'd0);
        check("R1 vec", 32'(vec_out), 32'd0);
        check("R1 tset", 32'(tset_out), 32'd0);
        rst_n = 1'b1;

        // Load program A with full-word writes (R9 full)
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            host_we = 1'b1;
            host_full = 1'b1;
            host_addr = ADDR_W'(i);
            host_wdata = PROG_A[i];
        end
        @(negedge clk);
        host_we = 1'b0;

        // Table walk: R2 step, R3 counted loops, R5 branches, R7 timing set
        match_par = 1'b0;
        match_ser = 1'b1;
        pulse_start();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check($sformatf("R2/R3/R5/R7 stream[%0d]", i), 32'({vec_valid, tset_out, vec_out}), 32'(EXP_A[i]));
        end
        @(negedge clk);
        check("R8 halt valid", 32'(vec_valid), 32'd0);
        check("R8 halt active", 32'(active), 32'd0);
        check("R8 halt keeps vec", 32'(vec_out), 32'h1D);
        match_ser = 1'b0;

        // Load program B
        for (int i = 0; i < 5; i++) begin
            host_write(ADDR_W'(i), PROG_B[i], 1'b1);
        end

        // Until loop, wait, start ignored, trigger resume
        pulse_start();
        @(negedge clk);
        check("R2 first vec", 32'(vec_out), 32'h20);
        @(negedge clk);
        check("R4 until first", 32'(vec_out), 32'h21);
        @(negedge clk);
        check("R4 until repeats", 32'(vec_out), 32'h21);
        match_par = 1'b1;
        @(negedge clk);
        check("R4 until exit pass", 32'(vec_out), 32'h21);
        match_par = 1'b0;
        @(negedge clk);
        check("R6 wait vec", 32'(vec_out), 32'h22);
        @(negedge clk);
        check("R6 wait holds", 32'({vec_valid, vec_out}), 32'h122);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 start while waiting", 32'({active, vec_valid, vec_out}), 32'h322);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        check("R6 resume after trigger", 32'(vec_out), 32'h23);
        @(negedge clk);
        check("R8 halt after B", 32'({active, vec_valid}), 32'd0);

        // Vector-only write with halt opcode bits in the data: opcode must stay step
        host_write(ADDR_W'(0), {3'd7, 1'b0, 2'd0, 8'd0, 8'h66}, 1'b0);
        pulse_start();
        @(negedge clk);
        check("R9 vector-only keeps opcode", 32'({vec_valid, vec_out}), 32'h166);
        @(negedge clk);
        check("R4 until again", 32'(vec_out), 32'h21);
        host_we = 1'b1;
        host_full = 1'b0;
        host_addr = ADDR_W'(1);
        host_wdata = {3'd0, 1'b0, 2'd0, 8'd0, 8'h77};
        @(negedge clk);
        host_we = 1'b0;
        check("R10 same-cycle write reads old", 32'(vec_out), 32'h21);
        @(negedge clk);
        check("R10 new value next pass", 32'(vec_out), 32'h77);
        match_par = 1'b1;
        @(negedge clk);
        match_par = 1'b0;
        check("R9 until kept after write", 32'(vec_out), 32'h77);
        @(negedge clk);
        check("R6 wait in rerun", 32'(vec_out), 32'h22);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        check("R6 rerun resume", 32'(vec_out), 32'h23);
        @(negedge clk);
        check("R8 rerun halt", 32'({active, vec_valid}), 32'd0);

        // Reset in the middle of a run
        pulse_start();
        repeat (3) @(negedge clk);
        check("R4 spinning before reset", 32'({active, vec_out}), 32'h177);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 32'({active, vec_valid, tset_out, vec_out}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays idle", 32'({active, vec_valid}), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule